// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal by counting its rising edges over a fixed gate interval. A control word from the serial host takes effect on a frame-end strobe. It carries a run bit and a two-bit gate selection. Software first writes run = 0, which clears the counter. It then writes run = 1, which starts a measurement.

A start does not open the gate at once. A settling wait runs first, so that the input bias can stabilise, and its length depends on the gate selection. Both the wait and the gate are timed in whole periods of a 1 ms tick. The result stays on the `count` output until run is written back to 0. A separate completion line is meant for the serial output multiplexer. It is asserted when the gate closes and released by the next control frame.

The controller is one state machine with four states:
- `ST_IDLE` (cleared).
- `ST_WAIT` (settling).
- `ST_GATE` (counting).
- `ST_HOLD` (result held).

Its transitions are:
- **start**: `ST_IDLE` to `ST_WAIT`.
- **wait expiry**: `ST_WAIT` to `ST_GATE`.
- **gate expiry**: `ST_GATE` to `ST_HOLD`.
- **clear**: any state to `ST_IDLE`.
- In every other case the state is held.

While the synthesizer is inhibited, the timer and the counter are both frozen.

Top module: `ifc_gated_counter`

## Requirements
- R1: After reset, `count` is 0 and `done`, `busy` and `cmpl_low` are all 0.
- R2: A start is a `cfg_load` pulse with `cfg_run` = 1 while the latched run bit is 0. From the next cycle `busy` is 1. `cfg_gate` is captured at that moment with these gate lengths: 00 = 4 ticks, 01 = 8 ticks, 10 = 32 ticks, 11 = 64 ticks.
- R3: After a start the block waits for 4 ticks when `cfg_gate[1]` = 0 and for 8 ticks when `cfg_gate[1]` = 1. Edges that arrive during the wait are not counted, and `count` stays 0.
- R4: Edges are counted from the cycle after the last wait tick up to and including the cycle of the last gate tick. In the following cycle `done` becomes 1 and `busy` becomes 0.
- R5: While `done` is 1, `count` does not change. A `cfg_load` with `cfg_run` = 1 during a measurement or after it has no effect on state, timing, gate length or count.
- R6: A `cfg_load` with `cfg_run` = 0 has this effect from the next cycle, whatever the state: `count` = 0, `busy` = 0 and `done` = 0.
- R7: `cmpl_low` becomes 1 in the cycle after the gate ends. It becomes 0 in the cycle after any `cfg_load`. When `cfg_load` and the gate end fall in the same cycle, the load wins.
- R8: While `inhibit` = 1, ticks and edges are ignored. `count` and the measurement timing are frozen.
- R9: `count` saturates at 2^CNT_W−1 and does not wrap.
- R10: A rising edge is a cycle in which `if_in` = 1 after a cycle in which `if_in` = 0. `if_in` is sampled in every cycle, so a level that is already high when the gate opens is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick_1ms | input | 1 | One-cycle timing pulse, once per millisecond |
| if_in | input | 1 | Synchronised IF pulse input |
| inhibit | input | 1 | Synthesizer inhibit; freezes measurement |
| cfg_load | input | 1 | Frame-end strobe; applies cfg_run and cfg_gate |
| cfg_run | input | 1 | Run bit: 0 clears, 0→1 starts |
| cfg_gate | input | 2 | Gate-time selection |
| count | output | CNT_W | Edge count (MSB is bit CNT_W−1) |
| done | output | 1 | Measurement complete, result held |
| busy | output | 1 | Waiting or gating |
| cmpl_low | output | 1 | Completion indication: 1 = drive line low |

## Verification
The assertions take for granted that these inputs are already synchronous to `clk`:
- `cfg_load` is a single-cycle strobe.
- `tick_1ms` is a single-cycle pulse.
- `if_in` is synchronous and needs no further synchronisation.

The bench keeps within these limits. It drives every input at the falling clock edge, pulses `cfg_load` for exactly one cycle, and raises `tick_1ms` once every 16 cycles. It shrinks the counter width so that saturation can be reached with a toggling input inside a 64-tick gate.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_GATE = 2'd2,
        ST_HOLD = 2'd3
    } ifc_state_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ifc_cfg_latch.sv
module ifc_cfg_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_load,
    input  logic cfg_run,
    output logic start_p,
    output logic clear_p
);
    logic run_q;

    // run bit as last applied at a frame end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (cfg_load) begin
            run_q <= cfg_run;
        end
    end

    always_comb begin
        start_p = cfg_load & cfg_run & ~run_q;
        clear_p = cfg_load & ~cfg_run;
    end

endmodule

// File: rtl/ifc_edge_count.sv
module ifc_edge_count #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             clear,
    input  logic             enable,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;

    assign rise = sig_in & ~prev_q;

    // previous level is tracked every cycle, gated or not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sig_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (enable && rise && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl
    import ifc_pkg::*;
#(
    parameter int WAIT_SHORT = 4,
    parameter int WAIT_LONG  = 8,
    parameter int GATE_T0    = 4,
    parameter int GATE_T1    = 8,
    parameter int GATE_T2    = 32,
    parameter int GATE_T3    = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       inhibit,
    input  logic       cfg_load,
    input  logic       start_p,
    input  logic       clear_p,
    input  logic [1:0] gate_sel,
    output logic       gate_open,
    output logic       busy,
    output logic       done,
    output logic       cmpl_low
);
    localparam int MAXLEN = max_of4(max_of4(GATE_T0, GATE_T1, GATE_T2, GATE_T3),
                                    WAIT_SHORT, WAIT_LONG, 1);
    localparam int TW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;

    ifc_state_t     state_q, state_d;
    logic [TW-1:0]  tcnt_q, tcnt_d;
    logic [TW-1:0]  wait_last_q, gate_last_q;
    logic [TW-1:0]  wait_last_sel, gate_last_sel;
    logic           tick_ok;
    logic           gate_end;
    logic           cmpl_q;

    assign tick_ok = tick & ~inhibit;

    // lengths picked by the selection at start time
    always_comb begin
        unique case (gate_sel)
            2'b00:   gate_last_sel = TW'(GATE_T0 - 1);
            2'b01:   gate_last_sel = TW'(GATE_T1 - 1);
            2'b10:   gate_last_sel = TW'(GATE_T2 - 1);
            default: gate_last_sel = TW'(GATE_T3 - 1);
        endcase
        wait_last_sel = gate_sel[1] ? TW'(WAIT_LONG - 1) : TW'(WAIT_SHORT - 1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        if (clear_p) begin
            state_d = ST_IDLE;
            tcnt_d  = '0;
        end else if (start_p) begin
            state_d = ST_WAIT;
            tcnt_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    tcnt_d = '0;
                end
                ST_WAIT: begin
                    if (tick_ok) begin
                        if (tcnt_q == wait_last_q) begin
                            state_d = ST_GATE;
                            tcnt_d  = '0;
                        end else begin
                            tcnt_d = tcnt_q + 1'b1;
                        end
                    end
                end
                ST_GATE: begin
                    if (tick_ok) begin
                        if (tcnt_q == gate_last_q) begin
                            state_d = ST_HOLD;
                            tcnt_d  = '0;
                        end else begin
                            tcnt_d = tcnt_q + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    tcnt_d = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            tcnt_q      <= '0;
            wait_last_q <= '0;
            gate_last_q <= '0;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
            if (start_p) begin
                wait_last_q <= wait_last_sel;
                gate_last_q <= gate_last_sel;
            end
        end
    end

    assign gate_end = (state_q == ST_GATE) && (state_d == ST_HOLD);

    // completion line: any frame releases it, gate end asserts it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmpl_q <= 1'b0;
        end else if (cfg_load) begin
            cmpl_q <= 1'b0;
        end else if (gate_end) begin
            cmpl_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        gate_open = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: busy = 1'b1;
            ST_GATE: begin
                busy      = 1'b1;
                gate_open = ~inhibit;
            end
            ST_HOLD: done = 1'b1;
        endcase
        cmpl_low = cmpl_q;
    end

endmodule

// File: rtl/ifc_gated_counter.sv
module ifc_gated_counter #(
    parameter int CNT_W      = 20,
    parameter int WAIT_SHORT = 4,
    parameter int WAIT_LONG  = 8,
    parameter int GATE_T0    = 4,
    parameter int GATE_T1    = 8,
    parameter int GATE_T2    = 32,
    parameter int GATE_T3    = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1ms,
    input  logic             if_in,
    input  logic             inhibit,
    input  logic             cfg_load,
    input  logic             cfg_run,
    input  logic [1:0]       cfg_gate,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             busy,
    output logic             cmpl_low
);
    logic start_p, clear_p, gate_open;

    ifc_cfg_latch u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_run  (cfg_run),
        .start_p  (start_p),
        .clear_p  (clear_p)
    );

    ifc_ctrl #(
        .WAIT_SHORT (WAIT_SHORT),
        .WAIT_LONG  (WAIT_LONG),
        .GATE_T0    (GATE_T0),
        .GATE_T1    (GATE_T1),
        .GATE_T2    (GATE_T2),
        .GATE_T3    (GATE_T3)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1ms),
        .inhibit   (inhibit),
        .cfg_load  (cfg_load),
        .start_p   (start_p),
        .clear_p   (clear_p),
        .gate_sel  (cfg_gate),
        .gate_open (gate_open),
        .busy      (busy),
        .done      (done),
        .cmpl_low  (cmpl_low)
    );

    ifc_edge_count #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (if_in),
        .clear  (start_p | clear_p),
        .enable (gate_open),
        .count  (count)
    );

endmodule

// File: rtl/ifc_checker.sv
module ifc_checker #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inhibit,
    input logic             cfg_load,
    input logic             cfg_run,
    input logic [CNT_W-1:0] count,
    input logic             done,
    input logic             busy,
    input logic             cmpl_low
);
    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_load) |=> (done && $stable(count)));

    // R6
    clear_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !cfg_run) |=> (count == '0 && !busy && !done));

    // R7
    cmpl_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !cmpl_low);

    // R7
    cmpl_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmpl_low) |-> $rose(done));

    // R8
    inhibit_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !cfg_load) |=> $stable(count));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ((count == $past(count)) || (count == $past(count) + CNT_W'(1))));

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> (count == '0));

endmodule

bind ifc_gated_counter ifc_checker #(.CNT_W(CNT_W)) u_ifc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inhibit  (inhibit),
    .cfg_load (cfg_load),
    .cfg_run  (cfg_run),
    .count    (count),
    .done     (done),
    .busy     (busy),
    .cmpl_low (cmpl_low)
);

// File: tb/tb_ifc_gated_counter.sv
module tb_ifc_gated_counter;
    localparam int CW = 8;
    localparam int TP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_1ms = 1'b0;
    logic          if_in = 1'b0;
    logic          inhibit = 1'b0;
    logic          cfg_load = 1'b0;
    logic          cfg_run = 1'b0;
    logic [1:0]    cfg_gate = 2'b00;
    logic [CW-1:0] count;
    logic          done, busy, cmpl_low;

    always #10 clk = ~clk;

    ifc_gated_counter #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .if_in(if_in),
        .inhibit(inhibit), .cfg_load(cfg_load), .cfg_run(cfg_run),
        .cfg_gate(cfg_gate), .count(count), .done(done), .busy(busy),
        .cmpl_low(cmpl_low)
    );

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    int    tog = 0;
    logic  hold_val = 1'b0;
    string cur_req = "R1";
    bit    finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: state 0 idle, 1 wait, 2 gate, 3 hold
    int m_state = 0, m_t = 0, m_wl = 0, m_gl = 0, m_cnt = 0;
    bit m_run = 0, m_prev = 0, m_cmpl = 0;
    localparam int MAXC = (1 << CW) - 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_t = 0; m_cnt = 0; m_run = 0; m_prev = 0; m_cmpl = 0;
        end else begin
            bit st, cl, rise, tk, gend;
            int lens[4];
            lens = '{4, 8, 32, 64};
            st   = cfg_load && cfg_run && !m_run;
            cl   = cfg_load && !cfg_run;
            rise = if_in && !m_prev;
            tk   = tick_1ms && !inhibit;
            gend = !cl && !st && m_state == 2 && tk && m_t == m_gl - 1;
            if (cl || st) m_cnt = 0;
            else if (m_state == 2 && !inhibit && rise && m_cnt < MAXC) m_cnt++;
            if (cfg_load) m_cmpl = 0;
            else if (gend) m_cmpl = 1;
            if (cl) begin
                m_state = 0; m_t = 0;
            end else if (st) begin
                m_state = 1; m_t = 0;
                m_gl = lens[cfg_gate];
                m_wl = cfg_gate[1] ? 8 : 4;
            end else if (m_state == 1 && tk) begin
                if (m_t == m_wl - 1) begin m_state = 2; m_t = 0; end
                else m_t++;
            end else if (m_state == 2 && tk) begin
                if (m_t == m_gl - 1) begin m_state = 3; m_t = 0; end
                else m_t++;
            end
            if (cfg_load) m_run = cfg_run;
            m_prev = if_in;
        end
    end

    // per-cycle comparison, then free-running stimulus
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !finished) begin
            chk(count == CW'(m_cnt), cur_req, "count", int'(count), m_cnt);
            chk(busy == (m_state == 1 || m_state == 2), cur_req, "busy",
                int'(busy), int'(m_state == 1 || m_state == 2));
            chk(done == (m_state == 3), cur_req, "done", int'(done), int'(m_state == 3));
            chk(cmpl_low == m_cmpl, cur_req, "cmpl_low", int'(cmpl_low), int'(m_cmpl));
        end
        tick_1ms = (cyc % TP) == (TP - 1);
        if (tog == 0) if_in = hold_val;
        else if (cyc % tog == 0) if_in = ~if_in;
    end

    task automatic frame(input bit run, input logic [1:0] g);
        @(negedge clk);
        cfg_load = 1'b1; cfg_run = run; cfg_gate = g;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    int snap;

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(count == 0 && !done && !busy && !cmpl_low, "R1", "reset outputs",
            int'({count, done, busy, cmpl_low}), 0);

        // R2 / R3 / R4: 4-tick gate, edge every 4 cycles
        cur_req = "R3"; tog = 2;
        frame(1'b0, 2'b00);
        frame(1'b1, 2'b00);
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        idle(2 * TP);
        chk(count == 0, "R3", "count during wait", int'(count), 0);
        cur_req = "R4";
        wait_done();
        idle(1);
        chk(count == CW'(16), "R4", "4-tick gate edges", int'(count), 16);
        chk(cmpl_low == 1'b1, "R7", "completion asserted", int'(cmpl_low), 1);

        // R6 clear from hold, then 8-tick gate with edge every 6 cycles
        cur_req = "R6";
        frame(1'b0, 2'b00);
        chk(count == 0 && !done && !busy, "R6", "clear from hold",
            int'({count, done, busy}), 0);
        cur_req = "R4"; tog = 3;
        frame(1'b1, 2'b01);
        wait_done();
        idle(1);
        chk(done == 1'b1, "R4", "8-tick gate done", int'(done), 1);

        // R6 clear in the middle of a 32-tick gate
        cur_req = "R6";
        frame(1'b0, 2'b00);
        frame(1'b1, 2'b10);
        idle(15 * TP);
        frame(1'b0, 2'b10);
        chk(count == 0 && !busy && !done, "R6", "clear mid-gate",
            int'({count, busy, done}), 0);

        // R5 restart attempt during a running 32-tick gate has no effect
        cur_req = "R5"; tog = 2;
        frame(1'b1, 2'b10);
        idle(12 * TP);
        frame(1'b1, 2'b00);
        wait_done();
        idle(1);
        chk(count == CW'(128), "R5", "32-tick gate unchanged by reload", int'(count), 128);
        snap = int'(count);
        cur_req = "R7";
        frame(1'b1, 2'b01);
        chk(cmpl_low == 1'b0, "R7", "completion released by frame", int'(cmpl_low), 0);
        idle(5 * TP);
        chk(done == 1'b1 && int'(count) == snap, "R5", "hold after reload",
            int'(count), snap);

        // R8 inhibit freezes count during the gate
        cur_req = "R8"; tog = 1;
        frame(1'b0, 2'b00);
        frame(1'b1, 2'b00);
        idle(6 * TP);
        inhibit = 1'b1;
        idle(2);
        snap = int'(count);
        idle(60);
        chk(int'(count) == snap && busy, "R8", "count frozen under inhibit",
            int'(count), snap);
        inhibit = 1'b0;
        wait_done();
        idle(1);

        // R9 saturation: 64-tick gate, edge every 2 cycles -> 512 edges
        cur_req = "R9";
        frame(1'b0, 2'b00);
        frame(1'b1, 2'b11);
        wait_done();
        idle(1);
        chk(count == CW'(MAXC), "R9", "saturated count", int'(count), MAXC);

        // R10 level held high gives no edge
        cur_req = "R10"; tog = 0; hold_val = 1'b1;
        frame(1'b0, 2'b00);
        frame(1'b1, 2'b00);
        wait_done();
        idle(1);
        chk(count == 0, "R10", "steady high level", int'(count), 0);
        hold_val = 1'b0;
        idle(4);
        frame(1'b0, 2'b00);
        idle(4);
        finish_run();
    end

endmodule